// File: doc/BRIEF.md
# TDM Serial Stream Receiver with Frame Convention Sensing

This block receives one time-division multiplexed serial input and turns it into bytes, each tagged with the number of its time slot. It runs from a single master clock of 32.768 MHz. Edge-level resolution is modelled with a tick enable, `half_en`, that pulses twice per master clock period, so every tick stands for one master clock edge. The frame pulse arrives at 8 kHz. The block works out the pulse polarity by itself. An active-low pulse selects the convention in which data is launched on a falling edge and sampled on the next rising edge. An active-high pulse selects the reversed convention. The current choice is reported on `gci_mode`.

The line rate is chosen with a 3-bit code. Each bit lasts 1, 2, 4, 8 or 16 master clocks, and each bit is sampled at its middle, where a real clock at that rate would have sampled it. A 4-bit offset delays the frame start from the frame pulse by 0 to 15 ticks, which is 0 to 7.5 master clocks. Bits are assembled MSB first. At the end of each slot the byte is presented with a one-cycle valid strobe and the slot index.

Top module: `tdm_rx_framer`

## Requirements
- R1: State advances only on clock cycles where `half_en` is 1; one such cycle is one tick, or half a master clock. `byte_valid` is never high in the cycle after a cycle without a tick.
- R2: A leading edge is a change of `fp_in` after its level has held for more than IDLE_MIN ticks. On each leading edge `gci_mode` takes the new level: 0 means falling-edge launch, 1 means rising-edge launch.
- R3: The frame origin tick is the leading-edge tick plus `frame_ofs` (0 to 15 ticks), plus one more tick when `gci_mode` is 0.
- R4: For a `rate_sel` value k from 0 to 4, one bit lasts 2^k master clocks (2^(k+1) ticks). Codes 5 to 7 behave as 4.
- R5: Bit g of a frame is sampled from `rx_in` at tick origin + g*2^(k+1) + 2^k, which is the middle of the bit.
- R6: Bits are assembled MSB first: bit 7 of `byte_out` holds the first bit sampled in the slot.
- R7: `byte_valid` is high for exactly one cycle, right after the tick that samples the eighth bit of a slot. `byte_out` and `chan_idx` change only together with it.
- R8: `chan_idx` is 0 for the first slot after an origin and counts up by one per slot. It wraps after 2^(CHW-k) slots; with the default CHW of 9 this gives 512, 256, 128, 64 or 32 slots.
- R9: During reset, all outputs are 0 and `gci_mode` is 0. After reset, no byte is produced before a frame origin.
- R10: An edge of `fp_in` that follows IDLE_MIN or fewer unchanged ticks, such as the trailing edge of a pulse, neither changes `gci_mode` nor restarts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock carrying the tick enable |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | Tick enable, one pulse per master clock edge |
| fp_in | input | 1 | 8 kHz frame pulse, either polarity |
| rx_in | input | 1 | Serial data input |
| rate_sel | input | 3 | Rate code k: 2^k master clocks per bit |
| frame_ofs | input | OFSW | Frame start offset in ticks |
| byte_out | output | 8 | Last assembled byte |
| chan_idx | output | CHW | Slot index of `byte_out` |
| byte_valid | output | 1 | One-cycle strobe for a new byte |
| gci_mode | output | 1 | 1 when the frame pulse is active high |

## Verification
The assertions assume that `half_en` and `fp_in` change only between clock edges. They also assume that frame pulses are shorter than IDLE_MIN ticks and are separated by idle stretches much longer than that, and that `rate_sel` and `frame_ofs` stay fixed while a frame is running. The bench meets these assumptions by driving every input on the falling clock edge. It sends two-tick pulses one frame length apart and resets the block before each configuration, so a change of idle level between sweeps is never seen as a pulse. Only the directed convention test changes the idle level on purpose. The sweep covers every rate code (including a clamped one), every offset and both polarities, with tick patterns both dense and thinned.

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer #(
  parameter int CHW      = 9,
  parameter int IDLE_MIN = 8,
  parameter int OFSW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_en,
  input  logic            fp_in,
  input  logic            rx_in,
  input  logic [2:0]      rate_sel,
  input  logic [OFSW-1:0] frame_ofs,
  output logic [7:0]      byte_out,
  output logic [CHW-1:0]  chan_idx,
  output logic            byte_valid,
  output logic            gci_mode
);
  localparam int RUNW = $clog2(IDLE_MIN + 1);
  localparam int DLYW = OFSW + 1;

  logic            fp_q, armed, lead, origin, running;
  logic [RUNW-1:0] run;
  logic [DLYW-1:0] dly, dly_load;
  logic [2:0]      k_new, k_q, bitn;
  logic [4:0]      pos, half_pos, last_pos;
  logic [6:0]      sh;
  logic [CHW-1:0]  chan_cnt, last_ch;

  assign lead     = (fp_in != fp_q) && (run == RUNW'(IDLE_MIN));
  assign dly_load = {1'b0, frame_ofs} + {{OFSW{1'b0}}, ~fp_in};
  assign origin   = (lead && dly_load == '0) || (!lead && armed && dly == DLYW'(1));
  assign k_new    = (rate_sel > 3'd4) ? 3'd4 : rate_sel;
  assign half_pos = 5'd1 << k_q;
  assign last_pos = 5'((6'd2 << k_q) - 6'd1);
  assign last_ch  = {CHW{1'b1}} >> k_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q     <= 1'b1;
      run      <= '0;
      gci_mode <= 1'b0;
      dly      <= '0;
      armed    <= 1'b0;
    end else if (half_en) begin
      fp_q <= fp_in;
      if (fp_in != fp_q)
        run <= '0;
      else if (run != RUNW'(IDLE_MIN))
        run <= run + 1'b1;
      if (lead) begin
        gci_mode <= fp_in;
        dly      <= dly_load;
        armed    <= (dly_load != '0);
      end else if (armed) begin
        dly <= dly - 1'b1;
        if (dly == DLYW'(1))
          armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      k_q        <= '0;
      pos        <= '0;
      bitn       <= '0;
      sh         <= '0;
      chan_cnt   <= '0;
      byte_out   <= '0;
      chan_idx   <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (half_en) begin
        if (origin) begin
          running  <= 1'b1;
          k_q      <= k_new;
          pos      <= 5'd1;
          bitn     <= '0;
          chan_cnt <= '0;
        end else if (running) begin
          pos <= (pos == last_pos) ? '0 : pos + 1'b1;
          if (pos == half_pos) begin
            sh   <= {sh[5:0], rx_in};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              byte_out   <= {sh, rx_in};
              chan_idx   <= chan_cnt;
              byte_valid <= 1'b1;
              chan_cnt   <= (chan_cnt == last_ch) ? '0 : chan_cnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

module tdm_rx_framer_chk #(
  parameter int CHW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           half_en,
  input logic           fp_in,
  input logic [7:0]     byte_out,
  input logic [CHW-1:0] chan_idx,
  input logic           byte_valid,
  input logic           gci_mode
);
  // R1
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> !byte_valid);
  // R2
  gci_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gci_mode) |-> $past(fp_in) && $past(half_en));
  // R2
  gci_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gci_mode) |-> !$past(fp_in) && $past(half_en));
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  // R7
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_out) |-> byte_valid);
  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_idx) |-> byte_valid);
  // R9
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (!byte_valid && chan_idx == '0 && byte_out == '0));
endmodule

bind tdm_rx_framer tdm_rx_framer_chk #(.CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .fp_in(fp_in),
  .byte_out(byte_out), .chan_idx(chan_idx), .byte_valid(byte_valid),
  .gci_mode(gci_mode)
);

// File: tb/tdm_rx_framer_bench.sv
module tdm_rx_framer_bench;
  localparam int CHW_TB = 4;
  localparam int FT     = (1 << CHW_TB) * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_en = 1'b0;
  logic fp_in = 1'b1;
  logic rx_in = 1'b0;
  logic [2:0] rate_sel = '0;
  logic [3:0] frame_ofs = '0;
  logic [7:0] byte_out;
  logic [CHW_TB-1:0] chan_idx;
  logic byte_valid, gci_mode;

  int checks = 0, fails = 0;
  int tk = -1;
  bit ticked = 0;
  int cyc = 0;
  int N, chans, O0, O1, L0, cur_k, cur_ofs;

  tdm_rx_framer #(.CHW(CHW_TB), .IDLE_MIN(8), .OFSW(4)) u_tdm_rx_framer (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .fp_in(fp_in), .rx_in(rx_in),
    .rate_sel(rate_sel), .frame_ofs(frame_ofs), .byte_out(byte_out),
    .chan_idx(chan_idx), .byte_valid(byte_valid), .gci_mode(gci_mode));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    ticked = half_en;
    if (half_en) tk++;
    cyc++;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [7:0] pat(int f, int c);
    return 8'((c * 37 + f * 101 + cur_ofs * 13 + cur_k * 7 + 90) & 255);
  endfunction

  function automatic logic rx_bit(int t);
    int f, o, g, c;
    logic [7:0] b;
    if (t < O0) return 1'b0;
    f = (t >= O1) ? 1 : 0;
    o = f ? O1 : O0;
    g = (t - o) / (2 * N);
    c = g / 8;
    if (c >= chans) return 1'b0;
    b = pat(f, c);
    return b[7 - (g % 8)];
  endfunction

  // R3 R4 R5: expected sample ticks follow origin and rate arithmetic
  task automatic monitor_step();
    int s, rel, f, o, c;
    bit ev;
    logic [7:0] eb;
    ev = 0; eb = '0; c = 0;
    if (ticked) begin
      s = tk;
      f = (s >= O1) ? 1 : 0;
      o = f ? O1 : O0;
      rel = s - o - N;
      if (rel >= 0 && rel % (16 * N) == 14 * N) begin
        c = rel / (16 * N);
        if (c < chans) begin ev = 1; eb = pat(f, c); end
      end
    end
    if (ev || byte_valid) begin
      checks++;
      if (byte_valid !== ev) begin
        fails++;
        $display("FAIL R7 valid at tick %0d k=%0d ofs=%0d: actual %b expected %b",
                 tk, cur_k, cur_ofs, byte_valid, ev);
      end else begin
        checks++;
        if (byte_out !== eb) begin
          fails++;
          $display("FAIL R6 byte at tick %0d k=%0d ofs=%0d: actual %h expected %h",
                   tk, cur_k, cur_ofs, byte_out, eb);
        end
        checks++;
        if (chan_idx !== CHW_TB'(c)) begin
          fails++;
          $display("FAIL R8 channel at tick %0d k=%0d: actual %0d expected %0d",
                   tk, cur_k, chan_idx, c);
        end
      end
    end
  endtask

  task automatic do_reset(logic idle);
    @(negedge clk);
    rst_n = 1'b0; half_en = 1'b0; fp_in = idle; rx_in = 1'b0;
    repeat (3) @(negedge clk);
    // R9
    checks++;
    if (byte_valid !== 1'b0 || chan_idx !== '0 || byte_out !== '0 || gci_mode !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset outputs: actual v=%b ch=%0d b=%h g=%b expected all 0",
               byte_valid, chan_idx, byte_out, gci_mode);
    end
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(int ksel, int ofs, bit gci, bit thin);
    do_reset(~gci);
    rate_sel = 3'(ksel);
    frame_ofs = 4'(ofs);
    cur_k = (ksel > 4) ? 4 : ksel;  // R4 clamp of codes 5..7
    cur_ofs = ofs;
    N = 1 << cur_k;
    chans = (1 << CHW_TB) >> cur_k;
    L0 = tk + 1 + 16;
    O0 = L0 + ofs + (gci ? 0 : 1);
    O1 = O0 + FT;
    while (tk < O1 + FT - 1) begin
      @(negedge clk);
      monitor_step();
      half_en = thin ? ((cyc % 3) != 2) : 1'b1;
      if (half_en) begin
        int t;
        t = tk + 1;
        fp_in = ((t >= L0 && t < L0 + 2) || (t >= L0 + FT && t < L0 + FT + 2)) ? gci : ~gci;
        rx_in = rx_bit(t);
      end
    end
    @(negedge clk);
    monitor_step();
    half_en = 1'b0;
    // R2 R10: trailing pulse edges must leave the sensed convention intact
    checks++;
    if (gci_mode !== gci) begin
      fails++;
      $display("FAIL R10 convention after frames: actual %b expected %b", gci_mode, gci);
    end
  endtask

  task automatic drive_ticks(logic lvl, int n);
    repeat (n) begin
      @(negedge clk);
      half_en = 1'b1; fp_in = lvl; rx_in = 1'b0;
    end
  endtask

  task automatic check_gci(logic exp, string tag);
    @(negedge clk);
    half_en = 1'b0;
    checks++;
    if (gci_mode !== exp) begin
      fails++;
      $display("FAIL %s convention flag: actual %b expected %b", tag, gci_mode, exp);
    end
  endtask

  initial begin
    O0 = 1 << 30; O1 = 1 << 30; N = 1; chans = 1; cur_k = 0; cur_ofs = 0;
    do_reset(1'b1);
    // R2: each leading edge after a long idle level re-decides the convention
    drive_ticks(1'b1, 20); drive_ticks(1'b0, 20); check_gci(1'b0, "R2");
    drive_ticks(1'b1, 20); check_gci(1'b1, "R2");
    drive_ticks(1'b0, 3);
    // R10: a short opposite glitch is not a leading edge
    drive_ticks(1'b1, 2); drive_ticks(1'b0, 20); check_gci(1'b0, "R10");

    // R1 R3 R4 R5 R6 R7 R8: sweep of rate, offset and polarity
    for (int k = 0; k < 5; k++)
      for (int o = 0; o < 16; o++)
        for (int g = 0; g < 2; g++)
          run_cfg(k, o, g[0], (o % 4) == 3);
    run_cfg(7, 3, 1'b0, 1'b0);  // R4
    run_cfg(5, 10, 1'b1, 1'b1); // R4 R1

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule